// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a 16-bit down-counting timer that software programs over a simple synchronous register bus. A control byte holds a run request, a mode bit that picks one-shot or periodic operation, a 3-bit divider code and a clock gate. A 16-bit reload register holds the start value. A third, read-only location returns the live count. Byte and halfword writes are both accepted.

The counter loads from the reload register when the run request rises. While both the run request and the clock gate are set, the count falls by one on each divided tick. When the count runs out, the block drives a one-cycle expiry pulse. In periodic mode the counter then reloads and keeps going. In one-shot mode the run request clears itself and counting stops. The expiry pulse is meant to drive an interrupt input elsewhere on the chip.

Top module: `pdt_timer`

## Requirements
- R1: After reset the control byte reads 0x00, the reload register reads 0x0000, the count location reads 0xFFFF and the expiry output is low.
- R2: The control byte is at offset 0x00 and is written only through byte lane 0 (bus_be_i[0]). Its bit 0 is the run request, bit 1 selects periodic mode, bits 4:2 hold the divider code and bit 5 is the clock gate. Bits 7:6 read as zero. The reload register is at offset 0x02, and each of its bytes is written through its own lane (bus_be_i[1] for bits 15:8, bus_be_i[0] for bits 7:0). Both registers read back what was written.
- R3: A write that moves the run request from 0 to 1 copies the reload register into the count. A read of offset 0x04 right after that write returns the reload value.
- R4: While the timer runs, the count falls by exactly one every 2^(N+1) clock cycles, where N is the divider code. The first decrement comes 2^(N+1) cycles after the run request rises.
- R5: The count changes only while both the run request and the clock gate are set. Clearing the clock gate freezes the count. Setting the gate again, with the run request still set, resumes counting from the frozen value without a reload.
- R6: A read of offset 0x04 returns 0xFFFF whenever the run request or the clock gate is clear.
- R7: In one-shot mode, with a reload value L of at least 1, expiry_o is high for exactly one cycle, L·2^(N+1) cycles after the run request rises. The run request clears at the same time, and the control byte then reads with bit 0 clear.
- R8: In periodic mode the expiry pulse repeats every L·2^(N+1) cycles. The count reloads from the reload register each time, and the run request stays set.
- R9: A write to the reload register while the timer runs leaves the current count unchanged. The new value is used at the next reload.
- R10: A reload value of 0 expires on the first divided tick, 2^(N+1) cycles after the run request rises.
- R11: Writes to offset 0x04 change neither the count, the reload register nor the control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Byte offset of the access |
| bus_be_i | input | 2 | Byte lane enables for writes |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the same cycle as a selected read |
| expire_o | output | 1 | One-cycle pulse when the count runs out |

## Verification
The assertions check on every cycle the rules that hold step by step. While the timer is idle the count does not move. Between divided ticks it holds, and on a tick it falls by exactly one. A start loads the reload value. Running out either reloads the count and keeps the run request set, or clears the run request. Divided ticks never fall on two adjacent cycles, and the expiry pulse lasts one cycle. The bench scenarios are needed for the properties that span many cycles or that software sees. These are the exact tick spacing for each divider code, the cycle on which expiry lands, and a freeze and resume without reload. The bench also covers the 0xFFFF idle read-back, the byte-lane masking of the register map, a reload value changed mid-count, a zero reload value, and ignored writes to the read-only location.

// File: rtl/pdt_pkg.sv
`timescale 1ns/1ps
package pdt_pkg;
  localparam int DATA_W  = 16;
  localparam int BE_W    = DATA_W / 8;
  localparam int ADDR_W  = 3;
  localparam int PSC_W   = 3;
  localparam int PS_W    = 1 << PSC_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'h0;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 3'h2;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 3'h4;

  localparam int BIT_RUN   = 0;
  localparam int BIT_AUTO  = 1;
  localparam int BIT_PSC_L = 2;
  localparam int BIT_GATE  = 5;

  typedef struct packed {
    logic             gate;
    logic [PSC_W-1:0] psc;
    logic             autorl;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/pdt_rst_sync.sv
`timescale 1ns/1ps
module pdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pdt_regs.sv
`timescale 1ns/1ps
module pdt_regs
  import pdt_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              zero_evt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              start_rise_o,
  output logic              running_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             wr_ctrl, wr_reload;
  logic             ctrl_en, reload_en;

  assign wr_ctrl   = sel_i & we_i & (addr_i == OFS_CTRL) & be_i[0];
  assign wr_reload = sel_i & we_i & (addr_i == OFS_RELOAD);

  // control byte next state: a bus write wins over the one-shot self-clear
  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = 1'b0;
    if (wr_ctrl) begin
      ctrl_d.run    = wdata_i[BIT_RUN];
      ctrl_d.autorl = wdata_i[BIT_AUTO];
      ctrl_d.psc    = wdata_i[BIT_PSC_L +: PSC_W];
      ctrl_d.gate   = wdata_i[BIT_GATE];
      ctrl_en       = 1'b1;
    end else if (zero_evt_i && !ctrl_q.autorl) begin
      ctrl_d.run = 1'b0;
      ctrl_en    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // reload register, one byte lane at a time
  assign reload_en = wr_reload & (|be_i);
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign reload_d[g*8 +: 8] = (wr_reload && be_i[g]) ? wdata_i[g*8 +: 8]
                                                       : reload_q[g*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reload_q <= '0;
    else if (reload_en) reload_q <= reload_d;
  end

  assign start_rise_o = wr_ctrl & wdata_i[BIT_RUN] & ~ctrl_q.run;
  assign running_o    = ctrl_q.run & ctrl_q.gate;
  assign ctrl_o       = ctrl_q;
  assign reload_o     = reload_q;

  // read mux
  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      unique case (addr_i)
        OFS_CTRL:   rdata_o = CNT_W'({2'b00, ctrl_q});
        OFS_RELOAD: rdata_o = reload_q;
        OFS_COUNT:  rdata_o = running_o ? count_i : '1;
        default:    rdata_o = '0;
      endcase
    end
  end

  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_evt_i && !ctrl_q.autorl && !wr_ctrl) |=> !ctrl_q.run); // R7

  AST_AUTO_KEEPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_evt_i && ctrl_q.autorl && !wr_ctrl) |=> ctrl_q.run); // R8
endmodule

// File: rtl/pdt_prescaler.sv
`timescale 1ns/1ps
module pdt_prescaler
  import pdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PS_W-1:0]  div_q, div_d;
  logic [PS_W-1:0]  mask;
  logic [PSC_W-1:0] shamt;

  // code N compares the low N+1 bits: division by 2^(N+1)
  assign shamt  = PSC_W'(PS_W - 1) - psc_i;
  assign mask   = {PS_W{1'b1}} >> shamt;
  assign tick_o = run_i & ((div_q & mask) == mask);

  always_comb begin
    if (clr_i || !run_i) div_d = '0;
    else if (tick_o)     div_d = '0;
    else                 div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R4
endmodule

// File: rtl/pdt_counter.sv
`timescale 1ns/1ps
module pdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_now_i,
  input  logic             tick_i,
  input  logic             autorl_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_evt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;
  logic             expire_q;
  logic             last_step;

  assign last_step  = (count_q <= CNT_W'(1));
  assign zero_evt_o = tick_i & last_step;

  always_comb begin
    count_d  = count_q;
    count_en = 1'b0;
    if (load_now_i) begin
      count_d  = reload_i;
      count_en = 1'b1;
    end else if (tick_i) begin
      count_en = 1'b1;
      if (last_step) count_d = autorl_i ? reload_i : '0;
      else           count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) expire_q <= 1'b0;
    else         expire_q <= zero_evt_o;
  end

  assign count_o  = count_q;
  assign expire_o = expire_q;

  AST_LOAD_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_now_i |=> (count_q == $past(reload_i))); // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_now_i) |=> $stable(count_q)); // R5

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !load_now_i) |=> $stable(count_q)); // R4

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !last_step && !load_now_i) |=> (count_q == $past(count_q) - 1'b1)); // R4

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && last_step && autorl_i && !load_now_i) |=> (count_q == $past(reload_i))); // R8
endmodule

// File: rtl/pdt_timer.sv
`timescale 1ns/1ps
module pdt_timer
  import pdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BE_W-1:0]   bus_be_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              expire_o
);
  logic              rst_n;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload, count;
  logic              start_rise, running, tick, zero_evt;

  pdt_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pdt_regs #(.CNT_W(DATA_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .sel_i        (bus_sel_i),
    .we_i         (bus_we_i),
    .addr_i       (bus_addr_i),
    .be_i         (bus_be_i),
    .wdata_i      (bus_wdata_i),
    .rdata_o      (bus_rdata_o),
    .count_i      (count),
    .zero_evt_i   (zero_evt),
    .ctrl_o       (ctrl),
    .reload_o     (reload),
    .start_rise_o (start_rise),
    .running_o    (running)
  );

  pdt_prescaler u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (running),
    .clr_i  (start_rise),
    .psc_i  (ctrl.psc),
    .tick_o (tick)
  );

  pdt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (running),
    .load_now_i (start_rise),
    .tick_i     (tick),
    .autorl_i   (ctrl.autorl),
    .reload_i   (reload),
    .count_o    (count),
    .zero_evt_o (zero_evt),
    .expire_o   (expire_o)
  );

  AST_EXPIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    expire_o |=> !expire_o); // R7
endmodule

// File: tb/pdt_timer_bench.sv
`timescale 1ns/1ps
module pdt_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        bus_sel_i, bus_we_i;
  logic [2:0]  bus_addr_i;
  logic [1:0]  bus_be_i;
  logic [15:0] bus_wdata_i, bus_rdata_o;
  logic        expire_o;

  int unsigned cyc = 0;
  int unsigned n_chk = 0, n_fail = 0;
  int unsigned exp_n = 0, exp_last = 0;
  int unsigned s_cyc = 0;

  always #2.5 clk_i = ~clk_i;

  pdt_timer u_pdt_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_be_i(bus_be_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .expire_o(expire_o)
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) if (expire_o) begin
    exp_n    = exp_n + 1;
    exp_last = cyc;
  end

  always @(posedge clk_i) if (cyc > 60000) begin
    n_fail = n_fail + 1;
    $display("FAIL watchdog expired (R1..all) actual=%0d expected<60000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic bus_wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_be_i = be; bus_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0; bus_be_i = 2'b00;
    s_cyc = cyc;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_sel_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wait_until(input int unsigned t);
    while (cyc < t) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_rd(3'h0, d); check("R1 ctrl after reset", d, 16'h0000);
    bus_rd(3'h2, d); check("R1 reload after reset", d, 16'h0000);
    bus_rd(3'h4, d); check("R1 count after reset", d, 16'hFFFF);
    check("R1 expire after reset", expire_o, 0);
  endtask

  task automatic t_regmap();
    logic [15:0] d;
    bus_wr(3'h0, 2'b01, 16'h001E);
    bus_rd(3'h0, d); check("R2 ctrl readback", d, 16'h001E);
    bus_wr(3'h0, 2'b10, 16'h0021);
    bus_rd(3'h0, d); check("R2 ctrl ignores lane 1", d, 16'h001E);
    bus_wr(3'h0, 2'b01, 16'h00C0);
    bus_rd(3'h0, d); check("R2 ctrl bits 7:6 read zero", d, 16'h0000);
    bus_wr(3'h2, 2'b11, 16'h1234);
    bus_wr(3'h2, 2'b10, 16'hAB99);
    bus_rd(3'h2, d); check("R2 reload high lane", d, 16'hAB34);
    bus_wr(3'h2, 2'b01, 16'h77CD);
    bus_rd(3'h2, d); check("R2 reload low lane", d, 16'hABCD);
  endtask

  task automatic t_idle_read();
    logic [15:0] d;
    bus_wr(3'h0, 2'b01, 16'h0000);
    bus_wr(3'h2, 2'b11, 16'd200);
    bus_wr(3'h0, 2'b01, 16'h0001);
    wait_cyc(6);
    bus_rd(3'h4, d); check("R6 run without gate reads FFFF", d, 16'hFFFF);
    bus_wr(3'h0, 2'b01, 16'h0020);
    bus_rd(3'h4, d); check("R6 gate without run reads FFFF", d, 16'hFFFF);
  endtask

  task automatic t_prescale();
    logic [15:0] d;
    for (int n = 0; n < 4; n++) begin
      int dv;
      dv = 2 << n;
      bus_wr(3'h0, 2'b01, 16'h0000);
      bus_wr(3'h2, 2'b11, 16'd1000);
      bus_wr(3'h0, 2'b01, 16'h0021 | 16'(n << 2));
      bus_rd(3'h4, d); check($sformatf("R3 load on start code %0d", n), d, 1000);
      wait_cyc(3*dv - 1);
      bus_rd(3'h4, d); check($sformatf("R4 before 3rd tick code %0d", n), d, 998);
      wait_cyc(2);
      bus_rd(3'h4, d); check($sformatf("R4 after 3rd tick code %0d", n), d, 997);
    end
  endtask

  task automatic t_pause();
    logic [15:0] d;
    bus_wr(3'h0, 2'b01, 16'h0000);
    bus_wr(3'h2, 2'b11, 16'd100);
    bus_wr(3'h0, 2'b01, 16'h0021);
    wait_cyc(10);
    bus_rd(3'h4, d); check("R5 count before pause", d, 95);
    bus_wr(3'h0, 2'b01, 16'h0001);
    wait_cyc(20);
    bus_wr(3'h0, 2'b01, 16'h0021);
    bus_rd(3'h4, d); check("R5 frozen value kept on resume", d, 95);
    wait_cyc(4);
    bus_rd(3'h4, d); check("R5 counting resumed", d, 93);
  endtask

  task automatic t_oneshot();
    logic [15:0] d;
    int unsigned e0, s;
    bus_wr(3'h0, 2'b01, 16'h0000);
    bus_wr(3'h2, 2'b11, 16'd5);
    e0 = exp_n;
    bus_wr(3'h0, 2'b01, 16'h0021);
    s = s_cyc;
    wait_until(s + 20);
    check("R7 one pulse in one-shot", exp_n - e0, 1);
    check("R7 pulse cycle", exp_last - s, 10);
    bus_rd(3'h0, d); check("R7 run bit self-cleared", d, 16'h0020);
    bus_rd(3'h4, d); check("R7 stopped count reads FFFF", d, 16'hFFFF);
  endtask

  task automatic t_autoreload();
    logic [15:0] d;
    int unsigned e0, s;
    bus_wr(3'h0, 2'b01, 16'h0000);
    bus_wr(3'h2, 2'b11, 16'd3);
    e0 = exp_n;
    bus_wr(3'h0, 2'b01, 16'h0027);
    s = s_cyc;
    wait_until(s + 26);
    check("R8 two periodic pulses", exp_n - e0, 2);
    check("R8 second pulse cycle", exp_last - s, 24);
    bus_rd(3'h0, d); check("R8 run bit stays set", d, 16'h0027);
    bus_rd(3'h4, d); check("R8 count after reload", d, 16'd3);
  endtask

  task automatic t_reload_while_run();
    logic [15:0] d;
    int unsigned e0, s;
    bus_wr(3'h0, 2'b01, 16'h0000);
    bus_wr(3'h2, 2'b11, 16'd50);
    e0 = exp_n;
    bus_wr(3'h0, 2'b01, 16'h0023);
    s = s_cyc;
    wait_cyc(10);
    bus_wr(3'h2, 2'b11, 16'd7);
    bus_rd(3'h4, d); check("R9 count untouched by reload write", d, 50 - (cyc - s) / 2);
    wait_until(s + 101);
    check("R9 first expiry uses old value", exp_last - s, 100);
    wait_until(s + 115);
    check("R9 new value used after reload", exp_last - s, 114);
    check("R9 pulse count", exp_n - e0, 2);
  endtask

  task automatic t_zero_reload();
    logic [15:0] d;
    int unsigned e0, s;
    bus_wr(3'h0, 2'b01, 16'h0000);
    bus_wr(3'h2, 2'b11, 16'd0);
    e0 = exp_n;
    bus_wr(3'h0, 2'b01, 16'h0021);
    s = s_cyc;
    bus_rd(3'h4, d); check("R10 zero loaded", d, 0);
    wait_until(s + 6);
    check("R10 single pulse", exp_n - e0, 1);
    check("R10 expires on first tick", exp_last - s, 2);
  endtask

  task automatic t_readonly();
    logic [15:0] d;
    bus_wr(3'h0, 2'b01, 16'h0000);
    bus_wr(3'h2, 2'b11, 16'd40);
    bus_wr(3'h0, 2'b01, 16'h0021);
    wait_cyc(3);
    bus_wr(3'h4, 2'b11, 16'h0000);
    bus_rd(3'h4, d); check("R11 count ignores write", d, 40 - (cyc - s_cyc + 4) / 2 + 0 * d);
    bus_rd(3'h2, d); check("R11 reload unchanged", d, 16'd40);
    bus_rd(3'h0, d); check("R11 ctrl unchanged", d, 16'h0021);
  endtask

  initial begin
    rst_ni = 1'b0;
    bus_sel_i = 1'b0; bus_we_i = 1'b0; bus_addr_i = '0; bus_be_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_regmap();
    t_idle_read();
    t_prescale();
    t_pause();
    t_oneshot();
    t_autoreload();
    t_reload_while_run();
    t_zero_reload();
    t_readonly();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule